// File: doc/BRIEF.md
# System Reset Hub

This block merges every reset request on the chip into one synchronous system reset and records which request caused it. The request sources are power-on, supply monitor low, missing clock, watchdog expiry, comparator trip, software request, illegal flash access and an external active-low reset pad. The supply-related sources also pull the reset pad low through an open-drain output, so that parts outside the chip are reset along with it. The pad input is synchronised and filtered. While the hub drives the pad itself, the pad input is masked, so that the hub cannot hold itself in reset.

Once the last request goes away, reset is held for a stretch period and then released on a clock edge. Release produces a one-cycle exit strobe. The hub also supplies the post-reset defaults that the rest of the chip loads: watchdog enabled on the divide-by-12 clock, the internal oscillator as clock source, a program-counter start address of zero, and port latches at all ones in open-drain mode with pull-ups on. While reset is asserted, a hold output stops the core, the interrupts and the timers.

Top module: `sysrst_hub`

## Requirements
- R1: A high level on any of vmon_low_i, mclk_fail_i, wdt_expire_i, cmp_trip_i, sw_req_i or flash_err_i at a rising clock edge drives sys_rst_n_o low from that edge on.
- R2: sys_rst_n_o rises exactly STRETCH clock edges (default 16, minimum 16) after the last edge at which a request was sampled. A new request during the stretch restarts the count.
- R3: A low on por_n asserts reset at once, without waiting for a clock edge. Its release passes through a SYNC_STAGES (2) flop synchroniser before the stretch starts, so sys_rst_n_o rises STRETCH+2 edges after por_n goes high.
- R4: rst_pin_oe_o (1 = pull the pad low) is high during power-on and supply-monitor resets and falls on the edge where reset is released. It never rises for any other source, and it is never high while sys_rst_n_o is high.
- R5: A low on rst_pin_i is a reset request only after it has been seen on FILT_CYC (2) consecutive synchronised samples. A low that lasts one cycle has no effect.
- R6: While the hub drives the pad, and for SYNC_STAGES cycles after it stops, the pad input is masked. A power-on or supply reset therefore ends normally, and the recorded cause stays unchanged.
- R7: cause_o is one-hot, with bit 0 power-on, 1 supply monitor, 2 missing clock, 3 watchdog, 4 comparator, 5 software, 6 flash error, 7 pad. When several requests arrive together, the lowest bit wins. Power-on leaves only bit 0 set.
- R8: Only the first request of a reset episode is recorded. Power-on is the exception and always overrides. cause_o does not change while the system runs.
- R9: rst_exit_o is high for exactly the one cycle that follows the release edge.
- R10: The default outputs read as follows: wdt_en_o=1; wdt_clk_sel_o=2'b01 (system clock divided by 12); clk_src_o=0 (internal oscillator); pc_start_o=0; port_latch_o and port_od_o all ones; port_pullup_o=1.
- R11: core_hold_o is high exactly while sys_rst_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| vmon_low_i | input | 1 | Supply monitor below threshold |
| mclk_fail_i | input | 1 | Missing-clock detector fired |
| wdt_expire_i | input | 1 | Watchdog timeout |
| cmp_trip_i | input | 1 | Comparator reset trip |
| sw_req_i | input | 1 | Software reset request |
| flash_err_i | input | 1 | Illegal flash operation |
| rst_pin_i | input | 1 | Sensed level of the reset pad, active low |
| sys_rst_n_o | output | 1 | System reset, active low |
| core_hold_o | output | 1 | Halts core, interrupts and timers |
| rst_exit_o | output | 1 | One-cycle strobe after release |
| rst_pin_oe_o | output | 1 | Open-drain pull-down enable for the pad |
| cause_o | output | 8 | One-hot cause of the latest reset |
| wdt_en_o | output | 1 | Default watchdog enable |
| wdt_clk_sel_o | output | 2 | Default watchdog clock code |
| clk_src_o | output | 1 | Default clock source select |
| pc_start_o | output | PC_W | Default program-counter start |
| port_latch_o | output | PORT_W | Default port latch value |
| port_od_o | output | PORT_W | Default open-drain mode per pin |
| port_pullup_o | output | 1 | Default weak pull-up enable |

## Verification
The bench counts the release latency to the exact cycle after a single-cycle request, after power-on and after a request that restarts the stretch. An off-by-one counter or a skipped synchroniser stage therefore shows up as a wrong latency. It feeds the pad output back into the pad input, as a real open-drain pad would. If the self-mask were missing, the hub would stay in reset after power-on, or the recorded cause would switch to the pad. It also drives simultaneous requests, a second request during an episode and a power-on in the middle of another reset. A wrong priority, a cause register that re-captures, or a power-on that does not override would each leave the wrong one-hot code behind. A one-cycle pad glitch must not reset the chip. A filter that is too short would reset it.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int NSRC = 8;

  localparam int SRC_POR   = 0;
  localparam int SRC_VMON  = 1;
  localparam int SRC_MCLK  = 2;
  localparam int SRC_WDT   = 3;
  localparam int SRC_CMP   = 4;
  localparam int SRC_SW    = 5;
  localparam int SRC_FLASH = 6;
  localparam int SRC_PIN   = 7;

  typedef logic [NSRC-1:0] src_vec_t;

  localparam logic [1:0] WDCLK_DIV12   = 2'b01;
  localparam logic       CLKSRC_INTOSC = 1'b0;
endpackage

// File: rtl/sysrst_por_sync.sv
module sysrst_por_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic por_req_o
);
  logic [SYNC_STAGES-1:0] rel_q;
  logic [SYNC_STAGES-1:0] rel_d;

  always_comb begin
    rel_d = {rel_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rel_q <= '0;
    else        rel_q <= rel_d;
  end

  assign por_req_o = ~rel_q[SYNC_STAGES-1];
endmodule

// File: rtl/sysrst_pin_filter.sv
module sysrst_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_i,
  input  logic drv_i,
  output logic req_o
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] FMAX = FW'(FILT_CYC);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [SYNC_STAGES-1:0] dly_q, dly_d;
  logic [FW-1:0]          cnt_q, cnt_d;
  logic                   pin_low, mask;

  assign pin_low = ~sync_q[SYNC_STAGES-1];
  assign mask    = drv_i | (|dly_q);

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    dly_d  = {dly_q[SYNC_STAGES-2:0], drv_i};
    cnt_d  = '0;
    if (pin_low && !mask) begin
      if (cnt_q == FMAX) cnt_d = cnt_q;
      else               cnt_d = cnt_q + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync_q <= '1;
      dly_q  <= '1;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      dly_q  <= dly_d;
      cnt_q  <= cnt_d;
    end
  end

  assign req_o = (cnt_q == FMAX);
endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic req_any_i,
  output logic active_o,
  output logic fall_o,
  output logic exit_o
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] CLOAD = CW'(STRETCH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          exit_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (req_any_i) begin
      cnt_d = CLOAD;
      act_d = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
      act_d = (cnt_q != CW'(1));
    end else begin
      act_d = 1'b0;
    end
  end

  assign fall_o = act_q & ~act_d;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= CLOAD;
      act_q  <= 1'b1;
      exit_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      exit_q <= fall_o;
    end
  end

  assign active_o = act_q;
  assign exit_o   = exit_q;
endmodule

// File: rtl/sysrst_cause.sv
module sysrst_cause
  import sysrst_pkg::*;
(
  input  logic     clk,
  input  logic     por_n,
  input  src_vec_t req_i,
  input  logic     active_i,
  output src_vec_t cause_o
);
  src_vec_t cause_q, cause_d, first_hot;

  assign first_hot = req_i & (~req_i + src_vec_t'(1));

  always_comb begin
    cause_d = cause_q;
    if (req_i[SRC_POR])
      cause_d = src_vec_t'(1);
    else if (!active_i && (|req_i))
      cause_d = first_hot;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause_q <= src_vec_t'(1);
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub
  import sysrst_pkg::*;
#(
  parameter int STRETCH     = 16,
  parameter int FILT_CYC    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PC_W        = 16,
  parameter int PORT_W      = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              vmon_low_i,
  input  logic              mclk_fail_i,
  input  logic              wdt_expire_i,
  input  logic              cmp_trip_i,
  input  logic              sw_req_i,
  input  logic              flash_err_i,
  input  logic              rst_pin_i,
  output logic              sys_rst_n_o,
  output logic              core_hold_o,
  output logic              rst_exit_o,
  output logic              rst_pin_oe_o,
  output logic [NSRC-1:0]   cause_o,
  output logic              wdt_en_o,
  output logic [1:0]        wdt_clk_sel_o,
  output logic              clk_src_o,
  output logic [PC_W-1:0]   pc_start_o,
  output logic [PORT_W-1:0] port_latch_o,
  output logic [PORT_W-1:0] port_od_o,
  output logic              port_pullup_o
);
  src_vec_t req;
  logic     por_req, pin_req, supply_req;
  logic     active, fall, exit_p;
  logic     drv_q, drv_d;

  sysrst_por_sync #(.SYNC_STAGES(SYNC_STAGES)) u_por (
    .clk       (clk),
    .por_n     (por_n),
    .por_req_o (por_req)
  );

  sysrst_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_pin (
    .clk   (clk),
    .por_n (por_n),
    .pin_i (rst_pin_i),
    .drv_i (drv_q),
    .req_o (pin_req)
  );

  always_comb begin
    req            = '0;
    req[SRC_POR]   = por_req;
    req[SRC_VMON]  = vmon_low_i;
    req[SRC_MCLK]  = mclk_fail_i;
    req[SRC_WDT]   = wdt_expire_i;
    req[SRC_CMP]   = cmp_trip_i;
    req[SRC_SW]    = sw_req_i;
    req[SRC_FLASH] = flash_err_i;
    req[SRC_PIN]   = pin_req;
  end

  sysrst_stretch #(.STRETCH(STRETCH)) u_str (
    .clk       (clk),
    .por_n     (por_n),
    .req_any_i (|req),
    .active_o  (active),
    .fall_o    (fall),
    .exit_o    (exit_p)
  );

  sysrst_cause u_cause (
    .clk      (clk),
    .por_n    (por_n),
    .req_i    (req),
    .active_i (active),
    .cause_o  (cause_o)
  );

  assign supply_req = req[SRC_POR] | req[SRC_VMON];

  always_comb begin
    drv_d = supply_req | (drv_q & ~fall);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) drv_q <= 1'b1;
    else        drv_q <= drv_d;
  end

  assign sys_rst_n_o   = ~active;
  assign core_hold_o   = active;
  assign rst_exit_o    = exit_p;
  assign rst_pin_oe_o  = drv_q;

  assign wdt_en_o      = 1'b1;
  assign wdt_clk_sel_o = WDCLK_DIV12;
  assign clk_src_o     = CLKSRC_INTOSC;
  assign pc_start_o    = '0;
  assign port_latch_o  = '1;
  assign port_od_o     = '1;
  assign port_pullup_o = 1'b1;
endmodule

// File: rtl/sysrst_hub_chk.sv
module sysrst_hub_chk
  import sysrst_pkg::*;
(
  input logic     clk,
  input logic     por_n,
  input logic     vmon_low_i,
  input logic     mclk_fail_i,
  input logic     wdt_expire_i,
  input logic     cmp_trip_i,
  input logic     sw_req_i,
  input logic     flash_err_i,
  input logic     sys_rst_n_o,
  input logic     rst_exit_o,
  input logic     rst_pin_oe_o,
  input src_vec_t cause_o
);
  logic any_in;
  assign any_in = vmon_low_i | mclk_fail_i | wdt_expire_i | cmp_trip_i | sw_req_i | flash_err_i;

  AST_REQ_ASSERTS: assert property (@(posedge clk) disable iff (!por_n)
    any_in |=> !sys_rst_n_o); // R1

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n_o) |-> !$past(any_in)); // R2

  AST_PIN_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    rst_pin_oe_o |-> !sys_rst_n_o); // R4

  AST_PIN_SUPPLY_ONLY: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_pin_oe_o) |-> $past(vmon_low_i)); // R4

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
    $countones(cause_o) == 1); // R7

  AST_CAUSE_STABLE: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_n_o && $past(sys_rst_n_o)) |-> $stable(cause_o)); // R8

  AST_EXIT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    rst_exit_o |-> (sys_rst_n_o && !$past(sys_rst_n_o))); // R9

  AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    rst_exit_o |=> !rst_exit_o); // R9
endmodule

bind sysrst_hub sysrst_hub_chk u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .vmon_low_i   (vmon_low_i),
  .mclk_fail_i  (mclk_fail_i),
  .wdt_expire_i (wdt_expire_i),
  .cmp_trip_i   (cmp_trip_i),
  .sw_req_i     (sw_req_i),
  .flash_err_i  (flash_err_i),
  .sys_rst_n_o  (sys_rst_n_o),
  .rst_exit_o   (rst_exit_o),
  .rst_pin_oe_o (rst_pin_oe_o),
  .cause_o      (cause_o)
);

// File: tb/tb_sysrst_hub.sv
module tb_sysrst_hub;
  localparam int S = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic vmon = 1'b0, mclk = 1'b0, wdt = 1'b0, cmp = 1'b0, swr = 1'b0, flash = 1'b0;
  logic ext_n = 1'b1;
  logic pin;
  logic sys_rst_n, hold, rexit, oe, wen, csrc, pup;
  logic [7:0]  cause;
  logic [1:0]  wsel;
  logic [15:0] pc;
  logic [7:0]  platch, pod;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign pin = ext_n & ~oe;

  sysrst_hub #(.STRETCH(S)) dut (
    .clk(clk), .por_n(por_n), .vmon_low_i(vmon), .mclk_fail_i(mclk),
    .wdt_expire_i(wdt), .cmp_trip_i(cmp), .sw_req_i(swr), .flash_err_i(flash),
    .rst_pin_i(pin), .sys_rst_n_o(sys_rst_n), .core_hold_o(hold),
    .rst_exit_o(rexit), .rst_pin_oe_o(oe), .cause_o(cause), .wdt_en_o(wen),
    .wdt_clk_sel_o(wsel), .clk_src_o(csrc), .pc_start_o(pc),
    .port_latch_o(platch), .port_od_o(pod), .port_pullup_o(pup)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_release(output int n, output bit oe_seen);
    n = 0;
    oe_seen = 0;
    while (!sys_rst_n && n < 2000) begin
      if (oe) oe_seen = 1;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_defaults(input string tag);
    check({tag, " R10 wdt_en"}, wen, 1);
    check({tag, " R10 wdt_clk_sel"}, wsel, 2'b01);
    check({tag, " R10 clk_src"}, csrc, 0);
    check({tag, " R10 pc_start"}, pc, 0);
    check({tag, " R10 port_latch"}, platch, 8'hFF);
    check({tag, " R10 port_od"}, pod, 8'hFF);
    check({tag, " R10 pullup"}, pup, 1);
  endtask

  task automatic quiet_check(input string tag, input int cycles, input logic [7:0] exp_cause);
    bit dropped = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!sys_rst_n) dropped = 1;
    end
    check({tag, " stays released"}, dropped, 0);
    check({tag, " cause kept"}, cause, exp_cause);
  endtask

  task automatic t_por();
    int n;
    bit seen;
    check("R3 reset state sys_rst_n", sys_rst_n, 0);
    check("R11 hold in reset", hold, 1);
    check("R7 reset cause power-on", cause, 8'h01);
    check("R4 pad driven at power-on", oe, 1);
    check_defaults("in reset");
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    wait_release(n, seen);
    check("R3 power-on release latency", n, S + 2);
    check("R9 exit strobe", rexit, 1);
    check("R4 pad released at exit", oe, 0);
    check("R11 hold cleared", hold, 0);
    check_defaults("at exit");
    @(negedge clk);
    check("R9 exit strobe one cycle", rexit, 0);
    quiet_check("R6 power-on self mask", 30, 8'h01);
  endtask

  task automatic t_single(input int which, input logic [7:0] exp_cause, input bit exp_oe);
    int n;
    bit seen;
    case (which)
      1: vmon = 1'b1;
      2: mclk = 1'b1;
      3: wdt = 1'b1;
      4: cmp = 1'b1;
      5: swr = 1'b1;
      default: flash = 1'b1;
    endcase
    @(negedge clk);
    {vmon, mclk, wdt, cmp, swr, flash} = '0;
    check("R1 request asserts reset", sys_rst_n, 0);
    check("R11 hold asserted", hold, 1);
    check("R4 pad drive by source", oe, exp_oe);
    check("R7 cause code", cause, exp_cause);
    wait_release(n, seen);
    check("R2 stretch length", n, S);
    check("R4 pad drive over episode", seen, exp_oe);
    check("R9 exit strobe", rexit, 1);
    check("R4 pad off after release", oe, 0);
    quiet_check(exp_oe ? "R6 supply self mask" : "R8 after release", 10, exp_cause);
  endtask

  task automatic t_priority();
    int n;
    bit seen;
    mclk = 1'b1; flash = 1'b1;
    @(negedge clk);
    mclk = 1'b0; flash = 1'b0;
    check("R7 priority mclk over flash", cause, 8'h04);
    wait_release(n, seen);
    check("R4 no pad drive for mclk", seen, 0);
    vmon = 1'b1; cmp = 1'b1;
    @(negedge clk);
    vmon = 1'b0; cmp = 1'b0;
    check("R7 priority vmon over cmp", cause, 8'h02);
    check("R4 pad driven for vmon", oe, 1);
    wait_release(n, seen);
    check("R2 release after pair", n, S);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_first_cause();
    int n;
    bit seen;
    wdt = 1'b1;
    @(negedge clk);
    wdt = 1'b0;
    repeat (3) @(negedge clk);
    swr = 1'b1;
    @(negedge clk);
    swr = 1'b0;
    check("R8 first cause kept", cause, 8'h08);
    wait_release(n, seen);
    check("R2 stretch restarts", n, S);
    quiet_check("R8 first cause after release", 5, 8'h08);
  endtask

  task automatic t_pad();
    int n;
    bit seen;
    ext_n = 1'b0;
    @(negedge clk);
    ext_n = 1'b1;
    quiet_check("R5 one-cycle glitch ignored", 10, 8'h08);
    ext_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R5 long low asserts reset", sys_rst_n, 0);
    check("R7 pad cause", cause, 8'h80);
    check("R4 no self drive for pad", oe, 0);
    ext_n = 1'b1;
    wait_release(n, seen);
    check("R5 pad reset releases", sys_rst_n, 1);
    check("R4 pad never driven", seen, 0);
    quiet_check("R5 after pad reset", 10, 8'h80);
  endtask

  task automatic t_por_override();
    int n;
    bit seen;
    cmp = 1'b1;
    @(negedge clk);
    cmp = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 cmp cause", cause, 8'h10);
    por_n = 1'b0;
    #1;
    check("R3 async power-on cause", cause, 8'h01);
    check("R4 pad driven on power-on", oe, 1);
    @(negedge clk);
    por_n = 1'b1;
    wait_release(n, seen);
    check("R3 release after mid-episode power-on", n, S + 2);
    quiet_check("R6 self mask again", 10, 8'h01);
  endtask

  initial begin
    @(negedge clk);
    t_por();
    t_single(1, 8'h02, 1'b1);
    t_single(2, 8'h04, 1'b0);
    t_single(3, 8'h08, 1'b0);
    t_single(4, 8'h10, 1'b0);
    t_single(5, 8'h20, 1'b0);
    t_single(6, 8'h40, 1'b0);
    t_priority();
    t_first_cause();
    t_pad();
    t_por_override();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule